// File: doc/BRIEF.md
# ECC Error Log Register Bank

This block records an in-band ECC error reported by the memory datapath and holds it for software. Each error strobe carries a type flag (correctable or uncorrectable), an address and a 16-bit syndrome. The first error after the log is cleared fills a 64-bit log word with its type, address and syndrome. Later errors cannot overwrite the address or syndrome. They can only add the other type bit.

A separate 16-bit status word records which error types have happened since software last cleared it. A 16-bit command word chooses which types drive the interrupt request line. That line is a level signal and stays high while any enabled status bit is set. A one-bit activate word gates the whole capture path.

Software reaches all four words through a small single-cycle register bus. Reads are combinational. Writes are committed on the clock edge. The type bits in the log word and in the status word are cleared by writing one to them.

Top module: `ecc_errlog_bank`

## Requirements
- R1: After synchronous reset, the log, status and command words read zero, the activate word reads ACTIVE_AT_RESET in bit 0, and irq is low.
- R2: Register index on bus_addr: 0 is activate, 1 is the log word, 2 is status, 3 is command. bus_rdata shows the selected word combinationally.
- R3: When the log type bits (bit 63 uncorrectable, bit 62 correctable) are both clear and an error is accepted, the log word reads as follows one cycle later. Bits 38:5 hold the error address, bits 61:46 hold the syndrome, and the matching type bit is set. Bits 45:39 and 4:0 read zero.
- R4: While either log type bit is set, a new error leaves the address and syndrome unchanged. It only sets its own type bit, which has no effect if that bit is already set.
- R5: Writing one to log bit 62 or 63 clears that bit. All other log bits ignore bus writes. So writing back a value just read clears exactly the type bits that were set and keeps the address and syndrome.
- R6: Each accepted error sets status bit 6 (correctable) or bit 7 (uncorrectable), whatever the state of the log. Writing one to a status bit clears it. All other status bits read zero.
- R7: Command bit 6 enables correctable reporting and bit 7 enables uncorrectable reporting. Both bits are read/write. All other command bits read zero.
- R8: irq is high exactly when (status bit 6 and command bit 6) or (status bit 7 and command bit 7). It follows register changes in the same cycle they become visible on the bus.
- R9: When activate bit 0 is zero, error strobes change neither the log word nor the status word.
- R10: If a bus clear of a type bit and an error that sets the same bit fall in the same cycle, the bit ends up set.
- R11: Once both log type bits have been cleared, the next error captures its own fresh address and syndrome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error strobe, one cycle per error |
| evt_uncorr | input | 1 | 1 = uncorrectable, 0 = correctable |
| evt_addr | input | 34 | Error address in 32-byte units (address bits 38:5) |
| evt_synd | input | 16 | Error syndrome |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data of the indexed register |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with ACTIVE_AT_RESET set to 1, so error strobes are accepted straight after reset. That lets the table of error sequences run without any setup writes. The inactive path is reached by clearing the activate word over the bus and then checking that a later strobe leaves both the log and the status untouched. The single parameter fixes only the reset value, so the same build also covers the lock, write-back clear, masking and same-cycle set-over-clear cases.

// File: rtl/ecc_errlog_pkg.sv
package ecc_errlog_pkg;

    // Bus geometry
    localparam int DATA_W   = 64;
    localparam int HALF_W   = 16;
    localparam int NUM_REGS = 4;
    localparam int IDX_W    = $clog2(NUM_REGS);

    // Log word field positions (software decodes these)
    localparam int ADDR_LO    = 5;
    localparam int ADDR_HI    = 38;
    localparam int ADDR_W     = ADDR_HI - ADDR_LO + 1;
    localparam int SYN_LO     = 46;
    localparam int SYN_W      = 16;
    localparam int SYN_HI     = SYN_LO + SYN_W - 1;
    localparam int LOG_CE_BIT = 62;
    localparam int LOG_UE_BIT = 63;

    // Status / command bit positions
    localparam int FLAG_CE_BIT = 6;
    localparam int FLAG_UE_BIT = 7;

    typedef enum logic [IDX_W-1:0] {
        IDX_ACT = 2'd0,
        IDX_LOG = 2'd1,
        IDX_STS = 2'd2,
        IDX_CMD = 2'd3
    } reg_idx_e;

    // Pair of type flags, uncorrectable in the upper bit
    typedef struct packed {
        logic ue;
        logic ce;
    } err_pair_t;

    typedef struct packed {
        logic              ue;
        logic              ce;
        logic [SYN_W-1:0]  synd;
        logic [ADDR_W-1:0] addr;
    } log_t;

    function automatic logic [DATA_W-1:0] pack_log(input log_t l);
        logic [DATA_W-1:0] w;
        w                 = '0;
        w[ADDR_HI:ADDR_LO] = l.addr;
        w[SYN_HI:SYN_LO]   = l.synd;
        w[LOG_CE_BIT]      = l.ce;
        w[LOG_UE_BIT]      = l.ue;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_pair(input err_pair_t p);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[FLAG_CE_BIT] = p.ce;
        w[FLAG_UE_BIT] = p.ue;
        return w;
    endfunction

endpackage

// File: rtl/ecc_reg_decode.sv
module ecc_reg_decode
    import ecc_errlog_pkg::*;
(
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [IDX_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]   rd_words [NUM_REGS],
    output logic [NUM_REGS-1:0] wr_hit,
    output logic [DATA_W-1:0]   bus_rdata
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign wr_hit[g] = bus_sel && bus_we && (bus_addr == IDX_W'(g));
    end

    assign bus_rdata = rd_words[bus_addr];

endmodule

// File: rtl/ecc_log_word.sv
module ecc_log_word
    import ecc_errlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  err_pair_t         set,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SYN_W-1:0]  synd,
    input  err_pair_t         clr,
    output log_t              log_q,
    output logic              locked
);

    log_t log_d;

    assign locked = log_q.ce || log_q.ue;

    always_comb begin
        log_d    = log_q;
        // a set arriving with a clear of the same bit wins
        log_d.ce = (log_q.ce && !clr.ce) || set.ce;
        log_d.ue = (log_q.ue && !clr.ue) || set.ue;
        // fields are frozen once a type bit is held
        if (!locked && (set.ce || set.ue)) begin
            log_d.addr = addr;
            log_d.synd = synd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            log_q <= '0;
        end else begin
            log_q <= log_d;
        end
    end

endmodule

// File: rtl/ecc_sts_cmd.sv
module ecc_sts_cmd
    import ecc_errlog_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  err_pair_t set,
    input  err_pair_t sts_clr,
    input  logic      cmd_we,
    input  err_pair_t cmd_wval,
    output err_pair_t sts_q,
    output err_pair_t cmd_q,
    output logic      irq
);

    logic [1:0] set_v, clr_v, wval_v, sts_v, cmd_v, hit_v;

    assign set_v  = set;
    assign clr_v  = sts_clr;
    assign wval_v = cmd_wval;

    for (genvar g = 0; g < 2; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                sts_v[g] <= 1'b0;
                cmd_v[g] <= 1'b0;
            end else begin
                sts_v[g] <= (sts_v[g] && !clr_v[g]) || set_v[g];
                if (cmd_we) begin
                    cmd_v[g] <= wval_v[g];
                end
            end
        end
        assign hit_v[g] = sts_v[g] && cmd_v[g];
    end

    assign sts_q = err_pair_t'(sts_v);
    assign cmd_q = err_pair_t'(cmd_v);
    assign irq   = |hit_v;

endmodule

// File: rtl/ecc_errlog_bank.sv
module ecc_errlog_bank
    import ecc_errlog_pkg::*;
#(
    parameter bit ACTIVE_AT_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic              evt_uncorr,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [SYN_W-1:0]  evt_synd,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [NUM_REGS-1:0] wr_hit;
    logic                wr_act, wr_log, wr_sts, wr_cmd;
    logic                act_q;
    log_t                log_q;
    logic                locked;
    err_pair_t           evt_set, log_clr, sts_clr, cmd_wval;
    err_pair_t           sts_q, cmd_q;
    logic [DATA_W-1:0]   rd_words [NUM_REGS];
    logic                unused_wdata;

    assign wr_act = wr_hit[IDX_ACT];
    assign wr_log = wr_hit[IDX_LOG];
    assign wr_sts = wr_hit[IDX_STS];
    assign wr_cmd = wr_hit[IDX_CMD];

    assign evt_set.ce = evt_valid && act_q && !evt_uncorr;
    assign evt_set.ue = evt_valid && act_q && evt_uncorr;

    assign log_clr.ce  = wr_log && bus_wdata[LOG_CE_BIT];
    assign log_clr.ue  = wr_log && bus_wdata[LOG_UE_BIT];
    assign sts_clr.ce  = wr_sts && bus_wdata[FLAG_CE_BIT];
    assign sts_clr.ue  = wr_sts && bus_wdata[FLAG_UE_BIT];
    assign cmd_wval.ce = bus_wdata[FLAG_CE_BIT];
    assign cmd_wval.ue = bus_wdata[FLAG_UE_BIT];

    assign unused_wdata = ^{bus_wdata[SYN_HI:FLAG_UE_BIT+1], bus_wdata[FLAG_CE_BIT-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= ACTIVE_AT_RESET;
        end else if (wr_act) begin
            act_q <= bus_wdata[0];
        end
    end

    ecc_log_word u_log (
        .clk    (clk),
        .rst    (rst),
        .set    (evt_set),
        .addr   (evt_addr),
        .synd   (evt_synd),
        .clr    (log_clr),
        .log_q  (log_q),
        .locked (locked)
    );

    ecc_sts_cmd u_sts (
        .clk      (clk),
        .rst      (rst),
        .set      (evt_set),
        .sts_clr  (sts_clr),
        .cmd_we   (wr_cmd),
        .cmd_wval (cmd_wval),
        .sts_q    (sts_q),
        .cmd_q    (cmd_q),
        .irq      (irq)
    );

    always_comb begin
        rd_words[IDX_ACT] = {{(DATA_W-1){1'b0}}, act_q};
        rd_words[IDX_LOG] = pack_log(log_q);
        rd_words[IDX_STS] = pack_pair(sts_q);
        rd_words[IDX_CMD] = pack_pair(cmd_q);
    end

    ecc_reg_decode u_dec (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .rd_words  (rd_words),
        .wr_hit    (wr_hit),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/ecc_errlog_chk.sv
module ecc_errlog_chk
    import ecc_errlog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              evt_valid,
    input logic              evt_uncorr,
    input logic              act_q,
    input logic              locked,
    input log_t              log_q,
    input err_pair_t         sts_q,
    input logic              wr_log,
    input logic              wr_sts,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq
);

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && act_q && !locked) |=> (log_q.ce || log_q.ue));

    // R4
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(log_q.addr) && $stable(log_q.synd)));

    // R5
    ce_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_log && bus_wdata[LOG_CE_BIT] && !(evt_valid && act_q && !evt_uncorr))
        |=> !log_q.ce);

    // R6
    sts_ue_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && act_q && evt_uncorr) |=> sts_q.ue);

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (sts_q.ce || sts_q.ue));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!act_q && !wr_log && !wr_sts) |=> ($stable(log_q) && $stable(sts_q)));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && bus_wdata[FLAG_CE_BIT] && evt_valid && act_q && !evt_uncorr)
        |=> sts_q.ce);

endmodule

bind ecc_errlog_bank ecc_errlog_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_valid  (evt_valid),
    .evt_uncorr (evt_uncorr),
    .act_q      (act_q),
    .locked     (locked),
    .log_q      (log_q),
    .sts_q      (sts_q),
    .wr_log     (wr_log),
    .wr_sts     (wr_sts),
    .bus_wdata  (bus_wdata),
    .irq        (irq)
);

// File: tb/test_ecc_errlog_bank.sv
module test_ecc_errlog_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic        evt_uncorr = 1'b0;
    logic [33:0] evt_addr = '0;
    logic [15:0] evt_synd = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ecc_errlog_bank #(.ACTIVE_AT_RESET(1'b1)) i_ecc_errlog_bank (
        .clk        (clk),
        .rst        (rst),
        .evt_valid  (evt_valid),
        .evt_uncorr (evt_uncorr),
        .evt_addr   (evt_addr),
        .evt_synd   (evt_synd),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq)
    );

    // {clear log, clear status, uncorrectable, address, syndrome}
    localparam logic [52:0] VEC [0:5] = '{
        {1'b0, 1'b0, 1'b0, 34'h2_3456_789A, 16'hBEEF},
        {1'b0, 1'b0, 1'b1, 34'h1_1111_1111, 16'h1234},
        {1'b1, 1'b1, 1'b1, 34'h3_FFFF_FFFF, 16'hFFFF},
        {1'b0, 1'b0, 1'b1, 34'h0_0000_0000, 16'h0000},
        {1'b1, 1'b0, 1'b0, 34'h0_0000_0001, 16'h8001},
        {1'b1, 1'b1, 1'b0, 34'h2_AAAA_5555, 16'h5A5A}
    };

    localparam logic [63:0] LOG_W1C = 64'hC000_0000_0000_0000;

    // bench model of the log and status words
    logic        m_ce, m_ue, s_ce, s_ue;
    logic [33:0] m_addr;
    logic [15:0] m_syn;

    function automatic logic [63:0] mk_log(input logic ue, input logic ce,
                                           input logic [15:0] s, input logic [33:0] a);
        return {ue, ce, s, 7'b0, a, 5'b0};
    endfunction

    function automatic logic [63:0] mk_flag(input logic ue, input logic ce);
        return {56'b0, ue, ce, 6'b0};
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] idx, output logic [63:0] data);
        bus_addr = idx;
        #1;
        data = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] idx, input logic [63:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = idx; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic ev(input logic u, input logic [33:0] a, input logic [15:0] s);
        @(negedge clk);
        evt_valid = 1'b1; evt_uncorr = u; evt_addr = a; evt_synd = s;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wr_ev(input logic [1:0] idx, input logic [63:0] data,
                         input logic u, input logic [33:0] a, input logic [15:0] s);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = idx; bus_wdata = data;
        evt_valid = 1'b1; evt_uncorr = u; evt_addr = a; evt_synd = s;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0; evt_valid = 1'b0;
    endtask

    task automatic model_event(input logic u, input logic [33:0] a, input logic [15:0] s);
        if (!(m_ce || m_ue)) begin
            m_addr = a;
            m_syn  = s;
        end
        if (u) begin m_ue = 1'b1; s_ue = 1'b1; end
        else   begin m_ce = 1'b1; s_ce = 1'b1; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] d, v;
        m_ce = 0; m_ue = 0; s_ce = 0; s_ue = 0; m_addr = '0; m_syn = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R2 index map
        rd(2'd1, d); check("R1 log", d, 64'h0);
        rd(2'd2, d); check("R1 status", d, 64'h0);
        rd(2'd3, d); check("R1 command", d, 64'h0);
        rd(2'd0, d); check("R1 R2 activate", d, 64'h1);
        check("R1 irq", {63'b0, irq}, 64'h0);

        // R7 command read/write, unused bits read zero
        wr(2'd3, 64'h0000_0000_0000_FFFF);
        rd(2'd3, d); check("R7 command mask", d, 64'h00C0);

        // table walk: R3 R4 R6 R8 R11
        for (int i = 0; i < 6; i++) begin
            logic        c_log, c_sts, u;
            logic [33:0] a;
            logic [15:0] s;
            {c_log, c_sts, u, a, s} = VEC[i];
            if (c_log) begin wr(2'd1, LOG_W1C); m_ce = 0; m_ue = 0; end
            if (c_sts) begin wr(2'd2, 64'h00C0); s_ce = 0; s_ue = 0; end
            ev(u, a, s);
            model_event(u, a, s);
            rd(2'd1, d); check($sformatf("R3 R4 R11 log vec%0d", i), d, mk_log(m_ue, m_ce, m_syn, m_addr));
            rd(2'd2, d); check($sformatf("R6 status vec%0d", i), d, mk_flag(s_ue, s_ce));
            check($sformatf("R8 irq vec%0d", i), {63'b0, irq}, {63'b0, (s_ce || s_ue)});
        end

        // R5 write back read value clears both type bits, fields kept
        ev(1'b1, 34'h1_0000_0000, 16'h0F0F);
        model_event(1'b1, 34'h1_0000_0000, 16'h0F0F);
        rd(2'd1, v); check("R4 other type added", v, mk_log(1'b1, 1'b1, m_syn, m_addr));
        wr(2'd1, v);
        rd(2'd1, d); check("R5 writeback both", d, mk_log(1'b0, 1'b0, m_syn, m_addr));
        m_ce = 0; m_ue = 0;

        // R11 fresh capture, then R5 writeback clears only the set bit
        ev(1'b0, 34'h0_1357_9BDF, 16'hC3C3);
        model_event(1'b0, 34'h0_1357_9BDF, 16'hC3C3);
        rd(2'd1, v); check("R11 fresh capture", v, mk_log(1'b0, 1'b1, 16'hC3C3, 34'h0_1357_9BDF));
        wr(2'd1, v);
        rd(2'd1, d); check("R5 writeback ce only", d, mk_log(1'b0, 1'b0, 16'hC3C3, 34'h0_1357_9BDF));
        m_ce = 0;

        // R6 status clears bit by bit; R8 follows
        wr(2'd2, 64'h0040);
        rd(2'd2, d); check("R6 status clear ce", d, 64'h0080);
        check("R8 irq with ue left", {63'b0, irq}, 64'h1);
        wr(2'd2, 64'h0080);
        rd(2'd2, d); check("R6 status clear ue", d, 64'h0000);
        check("R8 irq drop", {63'b0, irq}, 64'h0);

        // R8 masking by command
        wr(2'd3, 64'h0040);
        ev(1'b1, 34'h0_0000_0010, 16'h0001);
        rd(2'd2, d); check("R6 ue recorded", d, 64'h0080);
        check("R8 ue masked", {63'b0, irq}, 64'h0);
        wr(2'd3, 64'h0080);
        check("R8 ue enabled", {63'b0, irq}, 64'h1);
        wr(2'd2, 64'h00C0);
        check("R8 irq after clear", {63'b0, irq}, 64'h0);
        wr(2'd1, LOG_W1C);

        // R10 same-cycle clear and set
        ev(1'b0, 34'h0_0000_0AAA, 16'h1111);
        wr_ev(2'd1, LOG_W1C, 1'b0, 34'h0_0000_0BBB, 16'h2222);
        rd(2'd1, d); check("R10 log set wins", d, mk_log(1'b0, 1'b1, 16'h1111, 34'h0_0000_0AAA));
        wr_ev(2'd2, 64'h0040, 1'b0, 34'h0_0000_0CCC, 16'h3333);
        rd(2'd2, d); check("R10 status set wins", d, 64'h0040);

        // R9 inactive: strobes ignored
        wr(2'd1, LOG_W1C);
        wr(2'd2, 64'h00C0);
        wr(2'd0, 64'h0);
        rd(2'd0, d); check("R9 activate cleared", d, 64'h0);
        ev(1'b1, 34'h3_0000_0003, 16'h7777);
        rd(2'd1, d); check("R9 log untouched", d, mk_log(1'b0, 1'b0, 16'h1111, 34'h0_0000_0AAA));
        rd(2'd2, d); check("R9 status untouched", d, 64'h0);
        check("R9 irq low", {63'b0, irq}, 64'h0);
        wr(2'd0, 64'h1);
        rd(2'd0, d); check("R2 activate set", d, 64'h1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule